// File: doc/BRIEF.md
# Single-Outstanding Interrupt Buffer

This block gathers one-cycle event pulses from six device-side interrupt causes and shows them to a host one at a time. Each cause has a sticky pending latch, gated by a host-written enable byte. When no interrupt is on show, the highest-priority enabled pending cause is moved into a presentation register. That drives an active-low interrupt pin and a one-hot status byte naming the cause.

The host services the interrupt by pulsing a status-read strobe. That read clears the presented cause at once. The pin then stays high for two cycles, so that any following interrupt gives the host a fresh falling edge. A cause that arrives while another is on show stays latched until its turn. Repeats of a cause that is already latched count as one. One cycle after reset is released, the block injects a single "ready" event of its own.

Top module: `irq_single_buffer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `irq_n_o` is 1 and `status_o` is 0x00.
- R2: An event on an enabled idle source i, sampled at clock edge k, is presented after edge k+1: `irq_n_o` low and `status_o` equal to 1<<i. Source bits: 0 setup packet, 1 endpoint-0 buffer free, 2 OUT FIFO became non-empty, 3 enumeration done, 4 bus activity, 5 ready; bits 7:6 always read 0. While `irq_n_o` is high, `status_o` is 0x00.
- R3: An event whose enable bit (same bit position as the source) is 0 in the cycle it arrives is discarded. Setting the enable bit later does not raise it.
- R4: At most one source is presented at a time. Events that arrive while one is presented leave `irq_n_o` and `status_o` unchanged until a read.
- R5: A `stat_rd_i` pulse while an interrupt is presented clears it: after that edge `irq_n_o` is 1 and `status_o` is 0x00. A read while nothing is presented has no effect.
- R6: After a clearing read at edge j, `irq_n_o` stays 1 after edges j and j+1. A pending enabled source is presented after edge j+2.
- R7: When several enabled sources are pending, the lowest bit index is presented first (setup highest, ready lowest).
- R8: Repeated events on a source that is already pending produce a single presentation.
- R9: The ready source (bit 5) is raised once after reset release, if enable bit 5 is set on the first clock edge after release. It is presented after the second edge.
- R10: Clearing an enable bit does not withdraw an interrupt being presented. A pending source whose enable bit is 0 stays latched but is not chosen until its enable bit is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 6 | One-cycle event pulses, one per source |
| en_i | input | 8 | Enable byte written by the host; bits 5:0 used |
| stat_rd_i | input | 1 | Status read strobe, clears the presented interrupt |
| irq_n_o | output | 1 | Active-low interrupt pin |
| status_o | output | 8 | One-hot status of the presented source |

## Verification
An event sampled at one edge is latched there and presented after the next edge. The bench therefore drives every input at a falling edge and checks the pins two falling edges later. A clearing read acts on the edge that samples it, so the cleared pins are checked at the very next falling edge. The two-cycle high gap is checked at each of the following two falling edges, with the next source expected only after the third edge. The ready event follows the same rule from reset release: it is still absent after the first edge and present after the second.

// File: rtl/irq_single_buffer.sv
module irq_single_buffer #(
  parameter int NSRC    = 6,
  parameter int SW      = 8,
  parameter int RDY_IDX = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic [SW-1:0]   en_i,
  input  logic            stat_rd_i,
  output logic            irq_n_o,
  output logic [SW-1:0]   status_o
);

  localparam logic [NSRC-1:0] RDY_MASK = NSRC'(1) << RDY_IDX;

  logic [NSRC-1:0] pend_q, cur_q, newev, avail, pick, take;
  logic            gap_q, boot_q, busy;
  logic            unused_en_hi;

  assign unused_en_hi = ^en_i[SW-1:NSRC];
  assign busy   = |cur_q;
  assign newev  = (evt_i | (boot_q ? '0 : RDY_MASK)) & en_i[NSRC-1:0];
  assign avail  = pend_q & en_i[NSRC-1:0];
  assign pick   = avail & (~avail + NSRC'(1));
  assign take   = (!busy && !gap_q) ? pick : '0;

  assign irq_n_o  = ~busy;
  assign status_o = {{(SW-NSRC){1'b0}}, cur_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      cur_q  <= '0;
      gap_q  <= 1'b0;
      boot_q <= 1'b0;
    end else begin
      boot_q <= 1'b1;
      pend_q <= (pend_q | newev) & ~take;
      gap_q  <= 1'b0;
      if (busy && stat_rd_i) begin
        cur_q <= '0;
        gap_q <= 1'b1;
      end else if (!busy && !gap_q) begin
        cur_q <= pick;
      end
    end
  end

endmodule

module irq_single_buffer_chk #(
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stat_rd_i,
  input logic          irq_n_o,
  input logic [SW-1:0] status_o
);

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status_o) && status_o[SW-1:6] == '0);

  p_pin_matches_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n_o == (status_o == '0));

  p_hold_until_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n_o && !stat_rd_i) |=> (!irq_n_o && $stable(status_o)));

  p_clear_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n_o && stat_rd_i) |=> irq_n_o);

  p_new_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n_o) |=> irq_n_o);

endmodule

bind irq_single_buffer irq_single_buffer_chk #(.SW(SW)) i_chk (
  .clk(clk), .rst_n(rst_n), .stat_rd_i(stat_rd_i),
  .irq_n_o(irq_n_o), .status_o(status_o)
);

// File: tb/test_irq_single_buffer.sv
module test_irq_single_buffer;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] evt = '0;
  logic [7:0] en = 8'h3F;
  logic       rd = 1'b0;
  logic       irq_n;
  logic [7:0] status;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 0;

  always #(PERIOD/2) clk = ~clk;

  irq_single_buffer i_irq_single_buffer (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .en_i(en),
    .stat_rd_i(rd), .irq_n_o(irq_n), .status_o(status)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [8:0] exp);
    n_chk++;
    if ({irq_n, status} !== exp) begin
      n_fail++;
      $display("FAIL %s actual irq_n=%b status=%h expected irq_n=%b status=%h",
               req, irq_n, status, exp[8], exp[7:0]);
    end
  endtask

  task automatic pulse(input logic [5:0] m);
    evt = m; tick(); evt = '0;
  endtask

  task automatic rd_pulse();
    rd = 1'b1; tick(); rd = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 8'h3F;
    repeat (3) tick();
    chk("R1 in reset", 9'h100);
    rst_n = 1'b1;
    tick();
    chk("R1 first cycle / R9 not yet", 9'h100);
    tick();
    chk("R9 ready presented", {1'b0, 8'h20});
    rd_pulse();
    chk("R5 cleared after read", 9'h100);
    repeat (3) tick();
    chk("R9 ready only once", 9'h100);
  endtask

  task automatic t_each_source();
    for (int i = 0; i < 6; i++) begin
      pulse(6'(1 << i));
      tick();
      chk($sformatf("R2 source %0d", i), {1'b0, 8'(1 << i)});
      rd_pulse();
      tick(); tick();
    end
  endtask

  task automatic t_queue();
    pulse(6'h02); tick();
    chk("R2 src1", {1'b0, 8'h02});
    pulse(6'h35); tick();
    chk("R4 held while others arrive", {1'b0, 8'h02});
    rd_pulse();
    chk("R5 cleared", 9'h100);
    tick();
    chk("R6 still high", 9'h100);
    tick();
    chk("R7 setup first", {1'b0, 8'h01});
    rd_pulse(); tick(); tick();
    chk("R7 flags second", {1'b0, 8'h04});
    rd_pulse(); tick(); tick();
    chk("R7 bus activity third", {1'b0, 8'h10});
    rd_pulse(); tick(); tick();
    chk("R7 ready last", {1'b0, 8'h20});
    rd_pulse(); tick(); tick();
    chk("R7 queue drained", 9'h100);
  endtask

  task automatic t_merge();
    pulse(6'h04); tick();
    chk("R8 first presented", {1'b0, 8'h04});
    pulse(6'h08); pulse(6'h08); pulse(6'h08);
    rd_pulse(); tick(); tick();
    chk("R8 merged source presented", {1'b0, 8'h08});
    rd_pulse();
    repeat (4) tick();
    chk("R8 only one presentation", 9'h100);
  endtask

  task automatic t_mask();
    en = 8'h3D;
    pulse(6'h02);
    repeat (3) tick();
    chk("R3 disabled event ignored", 9'h100);
    en = 8'h3F;
    repeat (3) tick();
    chk("R3 later enable does not raise", 9'h100);
  endtask

  task automatic t_enable_change();
    pulse(6'h08); tick();
    chk("R10 presented", {1'b0, 8'h08});
    en = 8'h00;
    tick(); tick();
    chk("R10 not withdrawn by disable", {1'b0, 8'h08});
    en = 8'h3F;
    pulse(6'h10);
    en = 8'h2F;
    rd_pulse();
    repeat (3) tick();
    chk("R10 masked pending not chosen", 9'h100);
    en = 8'h3F;
    tick();
    chk("R10 re-enabled pending presented", {1'b0, 8'h10});
    rd_pulse(); tick(); tick();
  endtask

  task automatic t_idle_read();
    rd_pulse();
    chk("R5 idle read no effect", 9'h100);
    pulse(6'h01); tick();
    chk("R5 normal after idle read", {1'b0, 8'h01});
    rd_pulse(); tick(); tick();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tick();
    t_reset();
    t_each_source();
    t_queue();
    t_merge();
    t_mask();
    t_enable_change();
    t_idle_read();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule